// File: doc/BRIEF.md
# Filtered Edge and Pulse Event Counter

This block counts transitions on one external digital line. The line is brought into the clock domain by a two-stage synchronizer. It can then be inverted, and it passes through a glitch filter whose threshold is programmable in steps of eight clocks. Accepted transitions become count events. The block can count only rising transitions, which adds one per high pulse, or both transitions, which adds two per high pulse. Each event moves a 16-bit value up or down by one from a loaded start value.

Three sticky status bits report the following:
- an event that makes the value equal a programmed target;
- any counted event;
- a stretch of a programmed length with no event.

Software clears the bits by writing ones. The target and event bits can each drive the interrupt line. The block also reports how many clocks separate the two most recent counted events.

The value is loaded on the rising edge of the enable input or on a reload strobe. While the block is disabled, the filter follows its input without producing events.

Top module: `evcnt_top`

## Requirements
- R1: After reset, cnt_value, edge_gap and status are all zero and irq is low.
- R2: On the cycle that enable goes high, and on any reload strobe, cnt_value takes the value of cfg_start.
- R3: With cfg_both_edges = 0, only rising transitions of the filtered line are counted, so one high pulse moves the value by one.
- R4: With cfg_both_edges = 1, both transitions are counted, so one high pulse moves the value by two.
- R5: With cfg_down = 0 each event adds one, and with cfg_down = 1 each event subtracts one. Both directions wrap modulo 2^16, so 0 minus 1 gives 0xFFFF.
- R6: The filter accepts a level change only after it has held for cfg_filter*8+1 clocks. A change that lasts cfg_filter*8 clocks produces no event.
- R7: With cfg_invert = 1 the line is complemented before filtering, so in single-edge mode a low pulse is counted once.
- R8: status bit 0 (target) is set by the event that makes cnt_value equal cfg_target. It is not set again while the value stays equal with no further event.
- R9: status bit 1 (event) is set by every counted event. Each status bit stays set until a one is written to the same bit of clr_status.
- R10: With cfg_tmo_en = 1 and a non-zero cfg_tmo_len, status bit 2 (timeout) is set once, after cfg_tmo_len clocks pass with no counted event. The timeout count restarts on each event and on each load.
- R11: edge_gap holds the number of clocks between the two most recent counted events. It saturates at 0xFFFF and is cleared on load.
- R12: irq is high exactly when (status bit 0 and irq_en bit 0) or (status bit 1 and irq_en bit 1). The timeout bit never drives irq.
- R13: While enable is low, transitions on the line leave cnt_value and the event status bit unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| sig_in | input | 1 | External line to be counted (asynchronous) |
| cfg_invert | input | 1 | Complement the line before filtering |
| cfg_filter | input | 8 | Filter threshold, in units of 8 clocks |
| cfg_both_edges | input | 1 | 0: rising only, 1: both transitions |
| cfg_down | input | 1 | 0: count up, 1: count down |
| cfg_start | input | 16 | Value loaded on enable or reload |
| cfg_target | input | 16 | Value that raises the target status |
| cfg_tmo_en | input | 1 | Arm the no-event timeout |
| cfg_tmo_len | input | 16 | Timeout length in clocks |
| irq_en | input | 2 | Bit 0: target to irq, bit 1: event to irq |
| enable | input | 1 | Run counting; rising edge loads the start value |
| reload | input | 1 | One-cycle strobe that reloads the start value |
| clr_status | input | 3 | Write-one-to-clear strobes for the status bits |
| cnt_value | output | 16 | Current count |
| edge_gap | output | 16 | Clocks between the last two events |
| status | output | 3 | Sticky flags: 0 target, 1 event, 2 timeout |
| irq | output | 1 | Interrupt request |

## Verification
The assertions check several properties on every cycle:
- the filtered level only ever moves to the current input level;
- cnt_value steps by exactly one on an event and is otherwise stable unless loaded;
- a target hit always coincides with the value equal to the target;
- the timeout pulse never repeats on back-to-back cycles;
- the interval counter stays saturated once it reaches its maximum;
- a status bit never drops without its clear strobe.

Only the bench scenarios can show the end-to-end behaviour:
- the exact threshold of the glitch filter;
- counts of one versus two per pulse;
- the effect of inversion;
- wrap-around when counting down;
- the one-shot nature of the target and timeout flags;
- the measured interval in clocks.

// File: rtl/evcnt_pkg.sv
// Package: shared constants for the event counter.
// Assumes status vector ordering is fixed: target, event, timeout.
package evcnt_pkg;
    localparam int ST_TARGET  = 0;
    localparam int ST_EVENT   = 1;
    localparam int ST_TIMEOUT = 2;
    localparam int ST_W       = 3;
    localparam int IRQ_W      = 2;
endpackage

// File: rtl/evcnt_filter.sv
// Module: synchronizes an asynchronous line, optionally inverts it and
// rejects level changes shorter than thresh*2^SCALE_LOG+1 clocks.
// Emits one-cycle rise/fall pulses on accepted changes.
// Assumes: while track_i is high the output follows the input with no pulses.
module evcnt_filter #(
    parameter int FILT_W    = 8,
    parameter int SCALE_LOG = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              raw_i,
    input  logic              invert_i,
    input  logic [FILT_W-1:0] thresh_i,
    input  logic              track_i,
    output logic              level_o,
    output logic              rise_o,
    output logic              fall_o
);
    localparam int RUN_W = FILT_W + SCALE_LOG + 1;

    logic             sync1_q, sync2_q;
    logic             inv_s;
    logic [RUN_W-1:0] need_s;
    logic [RUN_W-1:0] run_q;
    logic [RUN_W-1:0] run_inc_s;
    logic             level_q, rise_q, fall_q;

    // Two-flop synchronizer for the external line.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sync1_q <= 1'b0;
            sync2_q <= 1'b0;
        end else begin
            sync1_q <= raw_i;
            sync2_q <= sync1_q;
        end
    end

    // Polarity select and required stable length.
    always_comb begin
        inv_s     = sync2_q ^ invert_i;
        need_s    = {1'b0, thresh_i, {SCALE_LOG{1'b0}}} + RUN_W'(1);
        run_inc_s = run_q + RUN_W'(1);
    end

    // Count how long the input has differed from the filtered level.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            level_q <= 1'b0;
            run_q   <= '0;
            rise_q  <= 1'b0;
            fall_q  <= 1'b0;
        end else begin
            rise_q <= 1'b0;
            fall_q <= 1'b0;
            if (track_i) begin
                level_q <= inv_s;
                run_q   <= '0;
            end else if (inv_s == level_q) begin
                run_q <= '0;
            end else if (run_inc_s >= need_s) begin
                level_q <= inv_s;
                rise_q  <= inv_s;
                fall_q  <= ~inv_s;
                run_q   <= '0;
            end else begin
                run_q <= run_inc_s;
            end
        end
    end

    assign level_o = level_q;
    assign rise_o  = rise_q;
    assign fall_o  = fall_q;

    // R6: the filtered level only ever moves to the present input level.
    p_level_follows_r6: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(level_q) |-> level_q == $past(inv_s));

    // R6: a pulse is reported only together with a level change.
    p_pulse_on_change_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (rise_q || fall_q) |-> !$stable(level_q));
endmodule

// File: rtl/evcnt_counter.sv
// Module: up/down event counter with start load and target detection.
// Assumes ev_i is already masked off during a load cycle.
module evcnt_counter #(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load_i,
    input  logic [CNT_W-1:0] start_i,
    input  logic             ev_i,
    input  logic             down_i,
    input  logic [CNT_W-1:0] target_i,
    output logic [CNT_W-1:0] value_o,
    output logic             tgt_hit_o
);
    localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

    logic [CNT_W-1:0] cur_q, nxt_s;
    logic             hit_q;

    // Next value after one event in the selected direction.
    always_comb nxt_s = down_i ? (cur_q - ONE) : (cur_q + ONE);

    // Value register and one-shot target hit.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cur_q <= '0;
            hit_q <= 1'b0;
        end else begin
            hit_q <= 1'b0;
            if (load_i) begin
                cur_q <= start_i;
            end else if (ev_i) begin
                cur_q <= nxt_s;
                hit_q <= (nxt_s == target_i);
            end
        end
    end

    assign value_o   = cur_q;
    assign tgt_hit_o = hit_q;

    // R5: each event moves the value by exactly one.
    p_step_one_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (ev_i && !load_i) |=> ((cur_q - $past(cur_q)) == ONE) || (($past(cur_q) - cur_q) == ONE));

    // R13: without event or load the value holds.
    p_hold_r13: assert property (@(posedge clk) disable iff (!rst_n)
        (!ev_i && !load_i) |=> $stable(cur_q));

    // R8: a target hit coincides with the value equal to the target.
    p_hit_match_r8: assert property (@(posedge clk) disable iff (!rst_n)
        hit_q |-> cur_q == $past(target_i));

    // R2: load brings in the start value.
    p_load_r2: assert property (@(posedge clk) disable iff (!rst_n)
        load_i |=> cur_q == $past(start_i));
endmodule

// File: rtl/evcnt_timing.sv
// Module: measures clocks between events (saturating) and raises a
// one-shot timeout after a programmed stretch with no event.
// Assumes load_i and ev_i are never high together.
module evcnt_timing #(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load_i,
    input  logic             run_i,
    input  logic             ev_i,
    input  logic             tmo_en_i,
    input  logic [CNT_W-1:0] tmo_len_i,
    output logic [CNT_W-1:0] interval_o,
    output logic             tmo_o
);
    localparam logic [CNT_W-1:0] MAXV = '1;
    localparam logic [CNT_W-1:0] ONE  = CNT_W'(1);

    logic [CNT_W-1:0] gap_q, ival_q, tcnt_q;
    logic             have_prev_q, tmo_q;

    // Interval measurement between successive events.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            gap_q       <= '0;
            ival_q      <= '0;
            have_prev_q <= 1'b0;
        end else if (load_i) begin
            gap_q       <= '0;
            ival_q      <= '0;
            have_prev_q <= 1'b0;
        end else if (ev_i) begin
            if (have_prev_q) ival_q <= gap_q;
            have_prev_q <= 1'b1;
            gap_q       <= ONE;
        end else if (run_i && gap_q != MAXV) begin
            gap_q <= gap_q + ONE;
        end
    end

    // No-event timeout counter, fires once per quiet stretch.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            tcnt_q <= '0;
            tmo_q  <= 1'b0;
        end else begin
            tmo_q <= 1'b0;
            if (load_i || ev_i || !tmo_en_i) begin
                tcnt_q <= '0;
            end else if (run_i && tmo_len_i != '0 && tcnt_q < tmo_len_i) begin
                tcnt_q <= tcnt_q + ONE;
                tmo_q  <= ((tcnt_q + ONE) == tmo_len_i);
            end
        end
    end

    assign interval_o = ival_q;
    assign tmo_o      = tmo_q;

    // R11: the gap counter stays saturated until an event or load.
    p_gap_sat_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (gap_q == MAXV && !ev_i && !load_i) |=> gap_q == MAXV);

    // R10: the timeout pulse is never two cycles long.
    p_tmo_once_r10: assert property (@(posedge clk) disable iff (!rst_n)
        tmo_q |=> !tmo_q);

    // R10: no timeout without the enable.
    p_tmo_armed_r10: assert property (@(posedge clk) disable iff (!rst_n)
        tmo_q |-> $past(tmo_en_i));
endmodule

// File: rtl/evcnt_top.sv
// Module: filtered edge/pulse event counter top level.
// Combines the filter, the counter and the timing unit, and holds
// the sticky status flags and the interrupt output.
// Assumes configuration is stable while enable is high.
module evcnt_top
    import evcnt_pkg::*;
#(
    parameter int CNT_W     = 16,
    parameter int FILT_W    = 8,
    parameter int SCALE_LOG = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              sig_in,
    input  logic              cfg_invert,
    input  logic [FILT_W-1:0] cfg_filter,
    input  logic              cfg_both_edges,
    input  logic              cfg_down,
    input  logic [CNT_W-1:0]  cfg_start,
    input  logic [CNT_W-1:0]  cfg_target,
    input  logic              cfg_tmo_en,
    input  logic [CNT_W-1:0]  cfg_tmo_len,
    input  logic [IRQ_W-1:0]  irq_en,
    input  logic              enable,
    input  logic              reload,
    input  logic [ST_W-1:0]   clr_status,
    output logic [CNT_W-1:0]  cnt_value,
    output logic [CNT_W-1:0]  edge_gap,
    output logic [ST_W-1:0]   status,
    output logic              irq
);
    logic            en_q;
    logic            load_s, ev_s;
    logic            level_s, rise_s, fall_s;
    logic            hit_s, tmo_s;
    logic [ST_W-1:0] set_s;
    logic [ST_W-1:0] status_q;

    // Remember enable to find its rising edge.
    always_ff @(posedge clk) begin
        if (!rst_n) en_q <= 1'b0;
        else        en_q <= enable;
    end

    // Load and event qualification.
    always_comb begin
        load_s = reload | (enable & ~en_q);
        ev_s   = enable & ~load_s & (rise_s | (cfg_both_edges & fall_s));
    end

    evcnt_filter #(.FILT_W(FILT_W), .SCALE_LOG(SCALE_LOG)) u_filter (
        .clk      (clk),
        .rst_n    (rst_n),
        .raw_i    (sig_in),
        .invert_i (cfg_invert),
        .thresh_i (cfg_filter),
        .track_i  (~enable),
        .level_o  (level_s),
        .rise_o   (rise_s),
        .fall_o   (fall_s)
    );

    evcnt_counter #(.CNT_W(CNT_W)) u_counter (
        .clk       (clk),
        .rst_n     (rst_n),
        .load_i    (load_s),
        .start_i   (cfg_start),
        .ev_i      (ev_s),
        .down_i    (cfg_down),
        .target_i  (cfg_target),
        .value_o   (cnt_value),
        .tgt_hit_o (hit_s)
    );

    evcnt_timing #(.CNT_W(CNT_W)) u_timing (
        .clk        (clk),
        .rst_n      (rst_n),
        .load_i     (load_s),
        .run_i      (enable),
        .ev_i       (ev_s),
        .tmo_en_i   (cfg_tmo_en),
        .tmo_len_i  (cfg_tmo_len),
        .interval_o (edge_gap),
        .tmo_o      (tmo_s)
    );

    // Set vector gathered in status bit order.
    always_comb begin
        set_s              = '0;
        set_s[ST_TARGET]   = hit_s;
        set_s[ST_EVENT]    = ev_s;
        set_s[ST_TIMEOUT]  = tmo_s;
    end

    // Sticky status, a new set wins over a clear in the same cycle.
    always_ff @(posedge clk) begin
        if (!rst_n) status_q <= '0;
        else        status_q <= (status_q & ~clr_status) | set_s;
    end

    assign status = status_q;
    assign irq    = |(status_q[IRQ_W-1:0] & irq_en);

    // R9: a status bit falls only through its clear strobe.
    generate
        for (genvar b = 0; b < ST_W; b++) begin : g_sticky
            p_sticky_r9: assert property (@(posedge clk) disable iff (!rst_n)
                (status_q[b] && !clr_status[b]) |=> status_q[b]);
        end
    endgenerate

    // R13: no event bit is raised while disabled.
    p_quiet_disabled_r13: assert property (@(posedge clk) disable iff (!rst_n)
        (!enable && !status_q[ST_EVENT]) |=> !status_q[ST_EVENT]);

    // R12: the timeout bit alone never raises the interrupt.
    p_irq_src_r12: assert property (@(posedge clk) disable iff (!rst_n)
        (status_q[IRQ_W-1:0] == '0) |-> !irq);
endmodule

// File: tb/evcnt_top_tb_top.sv
module evcnt_top_tb_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        sig_in = 1'b0;
    logic        cfg_invert = 1'b0;
    logic [7:0]  cfg_filter = '0;
    logic        cfg_both_edges = 1'b0;
    logic        cfg_down = 1'b0;
    logic [15:0] cfg_start = '0;
    logic [15:0] cfg_target = '0;
    logic        cfg_tmo_en = 1'b0;
    logic [15:0] cfg_tmo_len = '0;
    logic [1:0]  irq_en = '0;
    logic        enable = 1'b0;
    logic        reload = 1'b0;
    logic [2:0]  clr_status = '0;
    logic [15:0] cnt_value;
    logic [15:0] edge_gap;
    logic [2:0]  status;
    logic        irq;

    int n_checks = 0;
    int n_fails  = 0;
    bit done     = 1'b0;
    logic idle   = 1'b0;

    always #2 clk = ~clk;

    evcnt_top dut_i (
        .clk(clk), .rst_n(rst_n), .sig_in(sig_in), .cfg_invert(cfg_invert),
        .cfg_filter(cfg_filter), .cfg_both_edges(cfg_both_edges), .cfg_down(cfg_down),
        .cfg_start(cfg_start), .cfg_target(cfg_target), .cfg_tmo_en(cfg_tmo_en),
        .cfg_tmo_len(cfg_tmo_len), .irq_en(irq_en), .enable(enable), .reload(reload),
        .clr_status(clr_status), .cnt_value(cnt_value), .edge_gap(edge_gap),
        .status(status), .irq(irq)
    );

    typedef struct packed {
        logic        inv;
        logic        both;
        logic        down;
        logic [7:0]  filt;
        logic [15:0] start;
        logic [3:0]  npulse;
        logic [15:0] expect_v;
    } vec_t;

    localparam int NVEC = 6;
    localparam vec_t VECS [NVEC] = '{
        '{1'b0, 1'b0, 1'b0, 8'd0, 16'd10,  4'd3, 16'd13},    // R3 single edge up
        '{1'b0, 1'b1, 1'b0, 8'd0, 16'd10,  4'd3, 16'd16},    // R4 both edges up
        '{1'b0, 1'b0, 1'b1, 8'd2, 16'd100, 4'd4, 16'd96},    // R5 down, filtered
        '{1'b0, 1'b1, 1'b1, 8'd0, 16'd0,   4'd1, 16'hFFFE},  // R5 wrap
        '{1'b1, 1'b0, 1'b0, 8'd1, 16'd0,   4'd2, 16'd2},     // R7 inverted
        '{1'b1, 1'b1, 1'b0, 8'd3, 16'd5,   4'd2, 16'd9}      // R7 inverted, both
    };

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp_v);
        n_checks++;
        if (act !== exp_v) begin
            n_fails++;
            $display("FAIL %s: actual=0x%0h expected=0x%0h", tag, act, exp_v);
        end
    endtask

    task automatic wait_cyc(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic pulse(input int w, input int gap);
        sig_in = ~idle;
        wait_cyc(w);
        sig_in = idle;
        wait_cyc(gap);
    endtask

    task automatic clear_all();
        clr_status = 3'b111;
        wait_cyc(1);
        clr_status = 3'b000;
    endtask

    task automatic start_run();
        enable = 1'b0;
        sig_in = idle;
        wait_cyc(6);
        enable = 1'b1;
        wait_cyc(3);
    endtask

    task automatic summary();
        if (!done) begin
            done = 1'b1;
            $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fails);
            $finish;
        end
    endtask

    initial begin
        #(200000 * 4);
        n_checks++;
        n_fails++;
        $display("FAIL watchdog: actual=timeout expected=completion");
        summary();
    end

    initial begin
        wait_cyc(4);
        // R1 reset state
        check("R1 cnt_value", cnt_value, 0);
        check("R1 edge_gap", edge_gap, 0);
        check("R1 status", status, 0);
        check("R1 irq", irq, 0);
        rst_n = 1'b1;
        wait_cyc(2);

        // Vector table
        for (int i = 0; i < NVEC; i++) begin
            cfg_invert     = VECS[i].inv;
            cfg_both_edges = VECS[i].both;
            cfg_down       = VECS[i].down;
            cfg_filter     = VECS[i].filt;
            cfg_start      = VECS[i].start;
            idle           = VECS[i].inv;
            start_run();
            check("R2 load on enable", cnt_value, VECS[i].start);
            for (int p = 0; p < int'(VECS[i].npulse); p++)
                pulse(8 * int'(VECS[i].filt) + 4, 8 * int'(VECS[i].filt) + 4);
            wait_cyc(8 * int'(VECS[i].filt) + 20);
            check("R3/R4/R5/R7 vector count", cnt_value, VECS[i].expect_v);
        end

        // R6 filter threshold: filt=2 needs 17 clocks
        cfg_invert = 0; idle = 0; cfg_both_edges = 0; cfg_down = 0;
        cfg_filter = 8'd2; cfg_start = 16'd0;
        start_run();
        pulse(16, 40);
        check("R6 glitch of 16 rejected", cnt_value, 0);
        pulse(17, 40);
        check("R6 pulse of 17 accepted", cnt_value, 1);

        // R13 disabled: no counting, no event status
        cfg_filter = 8'd0;
        clear_all();
        enable = 1'b0;
        wait_cyc(2);
        pulse(5, 10);
        pulse(5, 10);
        check("R13 value held while disabled", cnt_value, 1);
        check("R13 no event status while disabled", status[1], 0);

        // R2 reload strobe
        cfg_start = 16'd7;
        start_run();
        pulse(4, 10);
        check("R2 counted before reload", cnt_value, 8);
        reload = 1'b1;
        wait_cyc(1);
        reload = 1'b0;
        wait_cyc(2);
        check("R2 reload value", cnt_value, 7);

        // R8 target, R9 event status, R12 irq
        cfg_start = 16'd0; cfg_target = 16'd2; irq_en = 2'b01;
        start_run();
        clear_all();
        pulse(4, 6);
        pulse(4, 6);
        wait_cyc(6);
        check("R8 target status set", status[0], 1);
        check("R12 irq from target", irq, 1);
        clear_all();
        wait_cyc(10);
        check("R8 target not re-raised while equal", status[0], 0);
        check("R12 irq low after clear", irq, 0);
        pulse(4, 10);
        check("R9 value past target", cnt_value, 3);
        check("R8 no target past it", status[0], 0);
        check("R9 event status set", status[1], 1);
        check("R12 event not enabled", irq, 0);
        irq_en = 2'b10;
        wait_cyc(1);
        check("R12 irq from event", irq, 1);
        wait_cyc(5);
        check("R9 event status sticky", status[1], 1);
        clr_status = 3'b010;
        wait_cyc(1);
        clr_status = 3'b000;
        wait_cyc(1);
        check("R9 event status cleared", status[1], 0);

        // R10 timeout
        irq_en = 2'b11; cfg_target = 16'hAAAA;
        cfg_tmo_en = 1'b1; cfg_tmo_len = 16'd50;
        enable = 1'b0;
        wait_cyc(4);
        enable = 1'b1;
        clear_all();
        wait_cyc(40);
        check("R10 no timeout early", status[2], 0);
        wait_cyc(20);
        check("R10 timeout raised", status[2], 1);
        check("R12 timeout does not drive irq", irq, 0);
        clear_all();
        wait_cyc(100);
        check("R10 timeout only once", status[2], 0);
        pulse(4, 60);
        check("R10 timeout after restart", status[2], 1);
        cfg_tmo_en = 1'b0;

        // R11 interval
        start_run();
        pulse(5, 32);
        pulse(5, 10);
        check("R11 interval 37", edge_gap, 37);
        pulse(5, 70000);
        pulse(5, 10);
        check("R11 interval saturates", edge_gap, 16'hFFFF);
        enable = 1'b0;
        wait_cyc(2);
        enable = 1'b1;
        wait_cyc(2);
        check("R11 interval cleared on load", edge_gap, 0);

        summary();
    end
endmodule